// File: doc/BRIEF.md
# HDLC Transmit FIFO with Status and Interrupt Flags

This block buffers bytes for an HDLC transmitter. A microprocessor writes bytes into a 128-entry, byte-wide FIFO. The transmitter reads the oldest byte from `rd_data`, asks for the next one with `pop`, and holds `pkt_active` high while it is sending a packet.

The block reports two live conditions: the FIFO is full, and the FIFO is low. Low means it is empty or holds fewer bytes than a 7-bit threshold. It also records four sticky events:
- full going high,
- low going high,
- a write attempted while full,
- a byte requested by the transmitter in the middle of a packet when none is stored.

All of these sit in one 8-bit status word. A read strobe on that word clears the sticky events. An interrupt line combines the events through a per-event enable mask.

Top module: `hdlc_tx_fifo_stat`

## Requirements
- R1: The FIFO holds up to 128 bytes, and `count` gives the current fill level (0 to 128). Status bit 6 (full) is 1 exactly when `count` is 128.
- R2: Status bit 5 (low) is 1 when `count` is 0 or when `count` is less than `low_thresh`. Otherwise it is 0.
- R3: Status bit 3 (full event) becomes 1 in the cycle after the full bit goes from 0 to 1. A full bit that simply stays high does not set it again.
- R4: Status bit 0 (low event) becomes 1 in the cycle after the low bit goes from 0 to 1. The low level present right after reset does not set it.
- R5: A write while `count` is 128 is discarded and sets status bit 2 (overwrite). The stored bytes stay unchanged, and the count stays the same unless a pop happens in that cycle.
- R6: A `pop` while `count` is 0 and `pkt_active` is 1 sets status bit 1 (underrun). A `pop` on an empty FIFO with `pkt_active` at 0 has no effect.
- R7: `stat_rd` high for one cycle clears status bits 3, 2, 1 and 0 on the next cycle. A bit whose event happens in that same cycle stays 1.
- R8: Status bits 7 and 4 always read 0.
- R9: `irq` is 1 whenever some status bit i (i = 0 to 3) is 1 while `irq_en[i]` is also 1.
- R10: Bytes leave in the order they were written, and `rd_data` shows the oldest byte whenever `count` is nonzero. A push and a pop in the same cycle on a FIFO that is neither empty nor full leave `count` unchanged.
- R11: After reset, `count` is 0, `irq` is 0, and the status word reads 0x20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Write strobe from the microprocessor |
| wr_data | input | 8 | Byte to write |
| pop | input | 1 | Transmitter request for the next byte |
| pkt_active | input | 1 | Transmitter is in the middle of a packet |
| rd_data | output | 8 | Oldest stored byte |
| low_thresh | input | 7 | Low-fill threshold |
| stat_rd | input | 1 | Status read strobe (clears the sticky events) |
| irq_en | input | 4 | Enable mask; bit i enables status bit i |
| stat_q | output | 8 | Status word |
| irq | output | 1 | Combined interrupt |
| count | output | 8 | Fill level |

## Verification
The bench builds the block with its default parameters: a depth of 128, 8-bit data and a 7-bit threshold. At that depth a burst of pushes fills the FIFO completely. This brings the full edge, writes into a full FIFO, and the boundary where the threshold equals the fill level within a few hundred cycles.

The directed phases drain the FIFO to empty under an active packet and then with no packet. They also line an event up with a status read in the same cycle. Random phases alternate push-heavy and pop-heavy traffic with changing thresholds and enable masks.

// File: rtl/hdlc_tx_fifo_stat.sv
module hdlc_tx_fifo_stat #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  parameter int THR_W = 7
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [DW-1:0]               wr_data,
  input  logic                        pop,
  input  logic                        pkt_active,
  output logic [DW-1:0]               rd_data,
  input  logic [THR_W-1:0]            low_thresh,
  input  logic                        stat_rd,
  input  logic [3:0]                  irq_en,
  output logic [7:0]                  stat_q,
  output logic                        irq,
  output logic [$clog2(DEPTH+1)-1:0]  count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] FULLV = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          full_d, low_d;
  logic [3:0]    sticky, ev;

  wire full    = cnt == FULLV;
  wire empty   = cnt == '0;
  wire low     = empty | (cnt < CW'(low_thresh));
  wire push_ok = wr_en & ~full;
  wire pop_ok  = pop & ~empty;

  assign ev = {full & ~full_d, wr_en & full, pop & empty & pkt_active, low & ~low_d};

  always_ff @(posedge clk)
    if (push_ok) mem[wp] <= wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp     <= '0;
      rp     <= '0;
      cnt    <= '0;
      full_d <= 1'b0;
      low_d  <= 1'b1;
      sticky <= '0;
    end else begin
      if (push_ok) wp <= wp + 1'b1;
      if (pop_ok)  rp <= rp + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      full_d <= full;
      low_d  <= low;
      sticky <= ev | (sticky & {4{~stat_rd}});
    end
  end

  assign rd_data = mem[rp];
  assign count   = cnt;
  assign stat_q  = {1'b0, full, low, 1'b0, sticky};
  assign irq     = |(sticky & irq_en);
endmodule

// File: rtl/hdlc_tx_fifo_stat_chk.sv
module hdlc_tx_fifo_stat_chk #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  parameter int THR_W = 7
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        wr_en,
  input logic                        pop,
  input logic                        pkt_active,
  input logic                        stat_rd,
  input logic [7:0]                  stat_q,
  input logic [$clog2(DEPTH+1)-1:0]  count
);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] FULLV = CW'(DEPTH);

  // R1
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULLV);

  // R3
  full_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[6]) |=> stat_q[3]);

  // R4
  low_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[5]) |=> stat_q[0]);

  // R5
  overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !pop && count == FULLV |=> stat_q[2] && count == FULLV);

  // R6
  underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop && pkt_active && count == '0 |=> stat_q[1]);

  // R7
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !wr_en && !pop |=> stat_q[2:1] == 2'b00);

  // R10
  pushpop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && pop && count != '0 && count != FULLV |=> $stable(count));
endmodule

bind hdlc_tx_fifo_stat hdlc_tx_fifo_stat_chk #(.DEPTH(DEPTH), .DW(DW), .THR_W(THR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .pop(pop), .pkt_active(pkt_active),
  .stat_rd(stat_rd), .stat_q(stat_q), .count(count)
);

// File: tb/hdlc_tx_fifo_stat_tb_top.sv
module hdlc_tx_fifo_stat_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, pop = 1'b0, pkt_active = 1'b0, stat_rd = 1'b0;
  logic [7:0] wr_data = '0;
  logic [6:0] low_thresh = 7'd4;
  logic [3:0] irq_en = 4'hF;
  logic [7:0] rd_data, stat_q, count;
  logic       irq;

  always #4 clk = ~clk;

  hdlc_tx_fifo_stat dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .pop(pop),
    .pkt_active(pkt_active), .rd_data(rd_data), .low_thresh(low_thresh),
    .stat_rd(stat_rd), .irq_en(irq_en), .stat_q(stat_q), .irq(irq), .count(count)
  );

  int checks = 0, fails = 0;
  bit [7:0] mq[$];
  bit mfp, mlp;
  bit [3:0] mst;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit m_low(int n);
    return n == 0 || n < int'(low_thresh);
  endfunction

  task automatic model_update();
    int n = mq.size();
    bit full = n == 128;
    bit empty = n == 0;
    bit low = m_low(n);
    bit [3:0] ev;
    ev = {full && !mfp, wr_en && full, pop && empty && pkt_active, low && !mlp};
    if (pop && !empty) void'(mq.pop_front());
    if (wr_en && !full) mq.push_back(wr_data);
    mst = ev | (mst & {4{!stat_rd}});
    mfp = full;
    mlp = low;
  endtask

  task automatic compare_all();
    int n = mq.size();
    chk("R1 count", count, n);
    chk("R1 full", stat_q[6], n == 128);
    chk("R2 low", stat_q[5], m_low(n));
    chk("R3 full event", stat_q[3], mst[3]);
    chk("R5 overwrite", stat_q[2], mst[2]);
    chk("R6 underrun", stat_q[1], mst[1]);
    chk("R4 low event", stat_q[0], mst[0]);
    chk("R8 zero bits", {stat_q[7], stat_q[4]}, 2'b00);
    chk("R9 irq", irq, |(mst & irq_en));
    if (n > 0) chk("R10 head", rd_data, mq[0]);
  endtask

  task automatic step(bit w, bit [7:0] d, bit p, bit rd);
    wr_en = w; wr_data = d; pop = p; stat_rd = rd;
    @(posedge clk);
    model_update();
    @(negedge clk);
    wr_en = 1'b0; pop = 1'b0; stat_rd = 1'b0;
    compare_all();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mfp = 1'b0; mlp = 1'b1; mst = '0;
    // R11
    chk("R11 reset status", stat_q, 8'h20);
    chk("R11 reset count", count, 0);
    chk("R11 reset irq", irq, 1'b0);
    compare_all();

    low_thresh = 7'd4;
    for (int i = 0; i < 5; i++) step(1'b1, 8'hA0 + 8'(i), 1'b0, 1'b0);
    step(1'b1, 8'h55, 1'b1, 1'b0);
    chk("R10 push+pop count", count, 5);
    for (int i = 0; i < 2; i++) step(1'b0, 8'h00, 1'b1, 1'b0);
    step(1'b0, 8'h00, 1'b0, 1'b0);
    chk("R4 low event after refall", stat_q[0], 1'b1);
    step(1'b0, 8'h00, 1'b0, 1'b1);
    chk("R7 clear", stat_q[3:0], 4'h0);

    low_thresh = 7'd0;
    while (mq.size() < 128) step(1'b1, 8'($urandom), 1'b0, 1'b0);
    step(1'b0, 8'h00, 1'b0, 1'b0);
    chk("R3 full event", stat_q[3], 1'b1);
    step(1'b0, 8'h00, 1'b0, 1'b1);
    step(1'b0, 8'h00, 1'b0, 1'b0);
    chk("R3 level does not reset", stat_q[3], 1'b0);
    step(1'b1, 8'hEE, 1'b0, 1'b0);
    chk("R5 count kept", count, 128);
    step(1'b1, 8'hEF, 1'b0, 1'b1);
    chk("R7 same-cycle event kept", stat_q[2], 1'b1);

    pkt_active = 1'b1;
    while (mq.size() > 0) step(1'b0, 8'h00, 1'b1, 1'b0);
    step(1'b0, 8'h00, 1'b0, 1'b1);
    step(1'b0, 8'h00, 1'b1, 1'b0);
    chk("R6 underrun set", stat_q[1], 1'b1);
    step(1'b0, 8'h00, 1'b1, 1'b1);
    chk("R7 underrun with read kept", stat_q[1], 1'b1);
    pkt_active = 1'b0;
    step(1'b0, 8'h00, 1'b0, 1'b1);
    step(1'b0, 8'h00, 1'b1, 1'b0);
    chk("R6 idle empty pop", stat_q[1], 1'b0);
    chk("R6 idle count", count, 0);

    for (int c = 0; c < 6000; c++) begin
      int wp_pct = ((c / 400) % 2 == 0) ? 75 : 30;
      if (c % 150 == 0) low_thresh = 7'($urandom_range(0, 127));
      if (c % 90 == 0) irq_en = 4'($urandom);
      if (c % 37 == 0) pkt_active = 1'($urandom);
      step(int'($urandom_range(0, 99)) < wp_pct, 8'($urandom),
           int'($urandom_range(0, 99)) < 100 - wp_pct, $urandom_range(0, 9) == 0);
    end
    finish_run();
  end
endmodule